// File: doc/BRIEF.md
# Half-Duplex Character Transmitter with NACK-Driven Retry

This block sends 8-bit characters over a single open-drain line that the far end can also pull low. It uses the asynchronous half-duplex character protocol of contact smart cards (T=0). Each character goes out as a low start bit, eight data bits least significant first, and an even parity bit. The transmitter then lets go of the line for the guard period. Halfway through the first guard bit it checks the line. A low level at that point is an error signal from the receiver, meaning the character was received wrongly.

A 3-bit retry limit sets what happens after such an error. With a limit of zero the error only stretches the frame by one bit time, and the transmitter goes on to the next character. With a non-zero limit the same character is sent again, starting right after the error bit and two guard bits. The number of resends is bounded by the limit, so a character goes out at most eight times. If the last allowed resend is also refused, an error flag is raised and the transmitter goes on. Characters come in through a valid/ready handshake. A free-running tick input sets the bit timing, with a fixed number of ticks per bit.

Top module: `t0_repeat_tx`

## Requirements
- R1: After reset, `chrReady` is 1, `busy` is 0, `iterErr` is 0 and `lineDriveLow` is 0, so the line is released.
- R2: Each transmission drives, in order, one start bit at 0, then data bits 0 to 7, then a parity bit. The parity bit is 1 exactly when the data byte has an odd number of ones. Each bit lasts TICKS_PER_BIT ticks. A 0 is sent by asserting `lineDriveLow` and a 1 by releasing it.
- R3: After the parity bit, `lineDriveLow` stays 0 for the whole guard period. The guard period is two bit times, or three when an error was signalled.
- R4: The line is checked for an error signal at tick TICKS_PER_BIT/2 of the first guard bit. A resend begins with its start bit in the cycle right after the three-bit-time guard period ends.
- R5: With a retry limit of 0, a character is sent once whatever the receiver signals, and `iterErr` stays 0.
- R6: With a retry limit m > 0, a character refused n times is sent min(n, m) + 1 times in total, and never more than 8 times.
- R7: `iterErr` becomes 1 when the retry limit is non-zero and the last allowed resend is also refused. The transmitter then returns to idle and is ready for the next character.
- R8: Accepting a new character clears `iterErr` and resets the resend count. The retry limit is captured at the same moment.
- R9: `chrReady` is 1 only while idle. A character is taken in on a clock edge where `chrValid` and `chrReady` are both 1. A character waiting behind a finished one starts its start bit two cycles after the previous guard period ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitTick | input | 1 | Bit-timing tick; TICKS_PER_BIT ticks make one bit |
| chrData | input | 8 | Character to send |
| chrValid | input | 1 | Character present on `chrData` |
| chrReady | output | 1 | Transmitter idle and able to accept a character |
| maxIter | input | 3 | Retry limit; 0 turns automatic resend off |
| lineIn | input | 1 | Level sensed on the shared line |
| lineDriveLow | output | 1 | Pull the shared line low when 1 |
| busy | output | 1 | A character is being sent or guarded |
| iterErr | output | 1 | Last character was refused beyond the retry limit |

## Verification
The assertions run on every cycle. They check that the resend count never exceeds the captured limit and stays at zero when resend is off. They check that a resend is begun only after a sampled error, that the error flag rises only after a refusal at the limit, and that accepting a character clears both the count and the flag. They also check that the line is driven only within the ten frame bits. Only the bench scenarios can show the bit-level content of each frame, the exact cycle where a resend or the next character starts, and the total number of transmissions. To check these, a modelled receiver refuses a chosen number of attempts, and the bench sweeps every retry limit against every refusal count.

// File: rtl/t0tx_pkg.sv
package t0tx_pkg;
  // Strobes from the control to the datapath
  typedef struct packed {
    logic load;     // capture a new character
    logic restart;  // clear bit and tick counters
    logic driveEn;  // frame bits may drive the line
  } txStrobe_t;

  // Timing marks from the datapath to the control
  typedef struct packed {
    logic bitEnd;   // last tick of the current bit
    logic midBit;   // sampling tick of the current bit
  } txTiming_t;
endpackage

// File: rtl/t0tx_datapath.sv
module t0tx_datapath
  import t0tx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 4,
  parameter int DATA_W        = 8,
  parameter int CNT_W         = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitTick,
  input  txStrobe_t         strobe,
  input  logic [DATA_W-1:0] chrData,
  output logic [CNT_W-1:0]  bitCnt,
  output txTiming_t         timing,
  output logic              lineDriveLow
);
  localparam int PH_W       = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam int FRAME_BITS = DATA_W + 2;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(TICKS_PER_BIT - 1);
  localparam logic [PH_W-1:0] PH_MID  = PH_W'(TICKS_PER_BIT / 2);

  logic [PH_W-1:0]   phase;
  logic [DATA_W-1:0] charReg;
  logic              frameBit;

  // Tick phase within a bit and bit position within the frame
  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= '0;
      bitCnt <= '0;
    end else if (strobe.restart) begin
      phase  <= '0;
      bitCnt <= '0;
    end else if (bitTick) begin
      if (phase == PH_LAST) begin
        phase  <= '0;
        bitCnt <= bitCnt + 1'b1;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            charReg <= '0;
    else if (strobe.load) charReg <= chrData;
  end

  always_comb begin
    timing.bitEnd = bitTick && (phase == PH_LAST);
    timing.midBit = bitTick && (phase == PH_MID);
  end

  // Frame bit: start (0), data LSB first, then even parity
  always_comb begin
    frameBit = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (bitCnt == CNT_W'(i + 1)) frameBit = charReg[i];
    end
    if (bitCnt == CNT_W'(DATA_W + 1)) frameBit = ^charReg;
  end

  assign lineDriveLow = strobe.driveEn & ~frameBit;

  // R3: the line is only pulled low inside the driven part of a frame
  assert_drive_in_frame_R3: assert property (@(posedge clk) disable iff (!rstN)
    lineDriveLow |-> (bitCnt < CNT_W'(FRAME_BITS)));
endmodule

// File: rtl/t0tx_ctrl.sv
module t0tx_ctrl
  import t0tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ITER_W = 3,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chrValid,
  input  logic [ITER_W-1:0] maxIter,
  input  logic              lineIn,
  input  txTiming_t         timing,
  input  logic [CNT_W-1:0]  bitCnt,
  output txStrobe_t         strobe,
  output logic              chrReady,
  output logic              busy,
  output logic              iterErr
);
  localparam int FRAME_BITS = DATA_W + 2;
  localparam logic [CNT_W-1:0] LAST_SEND = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] GUARD1    = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] GUARD_END = CNT_W'(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] NACK_END  = CNT_W'(FRAME_BITS + 2);

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_GUARD} txState_e;

  txState_e          state;
  logic [ITER_W-1:0] repCnt;
  logic [ITER_W-1:0] maxIterQ;
  logic              nack;
  logic              lastSendBit, guardDone, canRepeat, doRepeat;

  always_comb begin
    lastSendBit    = timing.bitEnd && (bitCnt == LAST_SEND);
    guardDone      = timing.bitEnd && (bitCnt == (nack ? NACK_END : GUARD_END));
    canRepeat      = nack && (maxIterQ != '0) && (repCnt < maxIterQ);
    doRepeat       = (state == ST_GUARD) && guardDone && canRepeat;
    strobe.load    = (state == ST_IDLE) && chrValid;
    strobe.restart = strobe.load || doRepeat;
    strobe.driveEn = (state == ST_SEND);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      repCnt   <= '0;
      maxIterQ <= '0;
      nack     <= 1'b0;
      iterErr  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (strobe.load) begin
          state    <= ST_SEND;
          repCnt   <= '0;
          maxIterQ <= maxIter;
          iterErr  <= 1'b0;
        end
        ST_SEND: if (lastSendBit) begin
          state <= ST_GUARD;
          nack  <= 1'b0;
        end
        ST_GUARD: begin
          if (timing.midBit && (bitCnt == GUARD1)) nack <= ~lineIn;
          if (guardDone) begin
            if (canRepeat) begin
              state  <= ST_SEND;
              repCnt <= repCnt + 1'b1;
            end else begin
              state <= ST_IDLE;
              if (nack && (maxIterQ != '0)) iterErr <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign chrReady = (state == ST_IDLE);
  assign busy     = (state != ST_IDLE);

  assert_rep_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    repCnt <= maxIterQ);

  assert_no_repeat_off_R5: assert property (@(posedge clk) disable iff (!rstN)
    (maxIterQ == '0) |-> (repCnt == '0) && !iterErr);

  assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(iterErr) |-> $past(nack) && ($past(maxIterQ) != '0) && ($past(repCnt) == $past(maxIterQ)));

  assert_clear_on_load_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (!iterErr && (repCnt == '0)));

  assert_repeat_after_nack_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_SEND) && ($past(state) == ST_GUARD)) |-> $past(nack));
endmodule

// File: rtl/t0_repeat_tx.sv
module t0_repeat_tx
  import t0tx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 4,
  parameter int DATA_W        = 8,
  parameter int ITER_W        = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitTick,
  input  logic [DATA_W-1:0] chrData,
  input  logic              chrValid,
  output logic              chrReady,
  input  logic [ITER_W-1:0] maxIter,
  input  logic              lineIn,
  output logic              lineDriveLow,
  output logic              busy,
  output logic              iterErr
);
  localparam int CNT_W = $clog2(DATA_W + 2 + 3);

  txStrobe_t        strobe;
  txTiming_t        timing;
  logic [CNT_W-1:0] bitCnt;

  t0tx_ctrl #(.DATA_W(DATA_W), .ITER_W(ITER_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .chrValid(chrValid), .maxIter(maxIter),
    .lineIn(lineIn), .timing(timing), .bitCnt(bitCnt), .strobe(strobe),
    .chrReady(chrReady), .busy(busy), .iterErr(iterErr)
  );

  t0tx_datapath #(.TICKS_PER_BIT(TICKS_PER_BIT), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .strobe(strobe),
    .chrData(chrData), .bitCnt(bitCnt), .timing(timing),
    .lineDriveLow(lineDriveLow)
  );
endmodule

// File: tb/t0_repeat_tx_tb.sv
module t0_repeat_tx_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitTick = 1'b1;
  logic [7:0] chrData = '0;
  logic       chrValid = 1'b0;
  logic [2:0] maxIter = '0;
  logic       chrReady, lineIn, lineDriveLow, busy, iterErr;
  logic       cardLow = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign lineIn = ~(lineDriveLow | cardLow);

  t0_repeat_tx u_dut (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .chrData(chrData),
    .chrValid(chrValid), .chrReady(chrReady), .maxIter(maxIter),
    .lineIn(lineIn), .lineDriveLow(lineDriveLow), .busy(busy), .iterErr(iterErr)
  );

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Receiver model: 4 ticks per bit, one tick per cycle
  int       frames = 0, charBase = 0, nackPlan = 0;
  int       cnt = 0, idleRun = 0, badFrames = 0, guardViol = 0;
  bit       inFrame = 0, nackNow = 0;
  logic [9:0] bits = '0;
  logic [7:0] rxLog [64];
  int       gapLog [64];

  always @(negedge clk) begin
    if (!rstN) begin
      inFrame = 0;
      cardLow = 1'b0;
      idleRun = 0;
    end else begin
      if (!inFrame) begin
        if (lineDriveLow) begin
          inFrame = 1;
          cnt = 0;
          nackNow = ((frames - charBase) < nackPlan);
          gapLog[frames % 64] = idleRun;
        end else begin
          idleRun++;
        end
      end else begin
        cnt++;
      end
      if (inFrame) begin
        if (cnt < 40 && (cnt % 4) == 2) bits[cnt/4] = lineIn;
        if (cnt >= 40 && lineDriveLow) guardViol++;
        if (cnt == (nackNow ? 51 : 47)) begin
          if (bits[0] != 1'b0 || bits[9] != ^bits[8:1]) badFrames++;
          rxLog[frames % 64] = bits[8:1];
          frames++;
          inFrame = 0;
          idleRun = 0;
        end
      end
      cardLow = inFrame && nackNow && cnt >= 40 && cnt <= 43;
    end
  end

  task automatic waitNeg();
    @(negedge clk);
    #1;
  endtask

  task automatic sendOne(input logic [7:0] data, input int m, input int n);
    int w;
    int expSends;
    string cntReq;
    waitNeg();
    chrData  = data;
    maxIter  = 3'(m);
    nackPlan = n;
    charBase = frames;
    chrValid = 1'b1;
    waitNeg();
    chrValid = 1'b0;
    check(busy == 1'b1, "R9 accept", int'(busy), 1);
    check(iterErr == 1'b0, "R8 clear on load", int'(iterErr), 0);
    w = 0;
    while (busy && w < 3000) begin
      waitNeg();
      w++;
    end
    waitNeg();
    expSends = (m == 0) ? 1 : (((n < m) ? n : m) + 1);
    cntReq = (m == 0) ? "R5 sends" : "R6 sends";
    check((frames - charBase) == expSends, cntReq, frames - charBase, expSends);
    for (int i = 0; i < expSends; i++) begin
      check(rxLog[(charBase + i) % 64] == data, "R2 data",
            int'(rxLog[(charBase + i) % 64]), int'(data));
      if (i > 0) check(gapLog[(charBase + i) % 64] == 0, "R4 resend start",
                       gapLog[(charBase + i) % 64], 0);
    end
    check(badFrames == 0, "R2 start/parity", badFrames, 0);
    check(guardViol == 0, "R3 guard release", guardViol, 0);
    check(iterErr == ((m > 0) && (n > m)), "R7 iterErr",
          int'(iterErr), int'((m > 0) && (n > m)));
    check(chrReady == 1'b1, "R7 back to idle", int'(chrReady), 1);
  endtask

  initial begin
    int w;
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;
    waitNeg();
    check(chrReady == 1'b1, "R1 ready", int'(chrReady), 1);
    check(busy == 1'b0, "R1 busy", int'(busy), 0);
    check(iterErr == 1'b0, "R1 iterErr", int'(iterErr), 0);
    check(lineDriveLow == 1'b0, "R1 line", int'(lineDriveLow), 0);

    // Every retry limit against every refusal count
    for (int m = 0; m < 8; m++) begin
      for (int n = 0; n < 9; n++) begin
        sendOne(8'((m * 37) + (n * 11) + 5), m, n);
      end
    end

    // R9: second character waits behind the first
    waitNeg();
    nackPlan = 0;
    maxIter  = 3'd2;
    charBase = frames;
    chrData  = 8'hA5;
    chrValid = 1'b1;
    waitNeg();
    chrData = 8'h3C;
    check(chrReady == 1'b0, "R9 not ready while busy", int'(chrReady), 0);
    w = 0;
    while (!(inFrame && (frames - charBase) == 1) && w < 500) begin
      waitNeg();
      w++;
    end
    chrValid = 1'b0;
    w = 0;
    while (busy && w < 500) begin
      waitNeg();
      w++;
    end
    waitNeg();
    check((frames - charBase) == 2, "R9 two chars", frames - charBase, 2);
    check(rxLog[charBase % 64] == 8'hA5, "R9 first", int'(rxLog[charBase % 64]), 8'hA5);
    check(rxLog[(charBase + 1) % 64] == 8'h3C, "R9 second",
          int'(rxLog[(charBase + 1) % 64]), 8'h3C);
    check(gapLog[(charBase + 1) % 64] == 1, "R9 next start gap",
          gapLog[(charBase + 1) % 64], 1);
    check(guardViol == 0, "R3 guard release", guardViol, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule